// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block recovers characters from an asynchronous serial line. A programmable divider turns the base clock into an oversampling tick. A receive state machine uses that tick to find a start bit, check it at mid-bit, and then sample each data bit, an optional parity bit and one stop bit at the end of every bit period. Characters are 7 or 8 bits long and arrive least-significant bit first. The finished character is held on `rxData`, with `rxValid` high, until the consumer pulses `readAck`.

Reception runs only while both the power enable and the receive enable are high. The receive enable passes through a two-stage synchroniser first. The parity selector has four settings: no parity bit, a parity bit that is read but never judged, odd parity and even parity. Every completed character updates three status flags: parity, framing and overrun. When any of them is set for that character, the block raises a one-cycle error interrupt.

Top module: `serial_rx_unit`

## Requirements
- R1: Data bits are taken least-significant bit first. The completed character appears on `rxData`, and `rxValid` goes high, once the stop bit has been sampled.
- R2: `charLen8`=1 receives 8 data bits. `charLen8`=0 receives 7 data bits, and `rxData[7]` then reads 0.
- R3: `parityMode` encoding: 2'b00 means no parity bit follows the data. 2'b01 means a parity bit follows but is never checked. 2'b10 checks odd parity. 2'b11 checks even parity.
- R4: In odd mode, `parityErr` is set when the data bits plus the parity bit hold an even number of ones.
- R5: In even mode, `parityErr` is set when the data bits plus the parity bit hold an odd number of ones.
- R6: In mode 2'b01, the parity bit is consumed whatever its level. `parityErr` stays 0 and no interrupt is raised for it.
- R7: Only one stop bit is examined. A low stop sample sets `frameErr`.
- R8: If a character completes while `rxValid` is still high and `readAck` is low, `overrunErr` is set and the new character replaces the old one.
- R9: `errIrq` pulses for exactly one cycle with the status update of a character that has any error flag set. It stays low for a clean character.
- R10: A `readAck` pulse clears `rxValid`.
- R11: A low level that is high again at the mid-bit check of the start bit is discarded. No character results.
- R12: With `powerOn` low, or with the synchronised `rxEnable` low, line activity is ignored. `powerOn` low also clears the outputs.
- R13: If `rxEnable` rises while the line is already low, that low level is taken as the start bit. Re-enabling must come at least two base clocks after disabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Active-low asynchronous reset |
| powerOn | input | 1 | Global power enable; low clears the receiver |
| rxEnable | input | 1 | Receive enable, synchronised internally |
| parityMode | input | 2 | Parity selection (see R3) |
| charLen8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| divisor | input | DIV_W | Base clocks per oversampling tick |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| readAck | input | 1 | Consumer has read the held character |
| rxData | output | 8 | Received character |
| rxValid | output | 1 | Character held and not yet read |
| parityErr | output | 1 | Parity error on the last character |
| frameErr | output | 1 | Stop bit sampled low on the last character |
| overrunErr | output | 1 | Last character overwrote an unread one |
| errIrq | output | 1 | One-cycle error interrupt |

## Verification
The bench builds the receiver with eight ticks per bit and a divisor of 2, which gives a 16-clock bit period. At that rate every parity setting, both character lengths, framing, overrun, start glitches and enable sequencing fit into a few thousand cycles. A small oversampling count still leaves half-bit margins for the mid-bit start check, so sampling skew from the synchroniser and the divider phase is exercised. The default sixteen-tick build is only elaborated.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } parMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       clear;
    logic       capture;
    logic [2:0] bitIdx;
    logic       parSample;
    logic       finish;
  } rxStrobe_t;

endpackage

// File: rtl/rx_baud_div.sv
module rx_baud_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] count;
  logic             wrapNow;

  // a divisor of 0 behaves like 1
  assign wrapNow = (divisor == '0) || (count >= divisor - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      tick  <= 1'b0;
    end else if (!run) begin
      count <= '0;
      tick  <= 1'b0;
    end else if (wrapNow) begin
      count <= '0;
      tick  <= 1'b1;
    end else begin
      count <= count + DIV_W'(1);
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       active,
  input  logic       tick,
  input  logic       rxBit,
  input  logic [1:0] parityMode,
  input  logic       charLen8,
  output rxStrobe_t  strb
);
  localparam int CNT_W = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} state_e;

  state_e     state;
  logic [CNT_W-1:0] cnt;
  logic [2:0] bitIdx;
  logic       midHit, fullHit, lastBit;

  assign midHit  = tick && (cnt == HALF_LAST);
  assign fullHit = tick && (cnt == FULL_LAST);
  assign lastBit = (bitIdx == (charLen8 ? 3'd7 : 3'd6));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (!active) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (tick) begin
      case (state)
        S_IDLE: begin
          cnt    <= '0;
          bitIdx <= '0;
          if (!rxBit) state <= S_START;
        end
        S_START: begin
          if (midHit) begin
            cnt   <= '0;
            state <= rxBit ? S_IDLE : S_DATA;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_DATA: begin
          if (fullHit) begin
            cnt <= '0;
            if (lastBit) begin
              bitIdx <= '0;
              state  <= (parityMode == PAR_NONE) ? S_STOP : S_PAR;
            end else begin
              bitIdx <= bitIdx + 3'd1;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_PAR: begin
          if (fullHit) begin
            cnt   <= '0;
            state <= S_STOP;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_STOP: begin
          if (fullHit) begin
            cnt   <= '0;
            state <= S_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.clear     = active && (state == S_IDLE) && tick && !rxBit;
    strb.capture   = active && (state == S_DATA) && fullHit;
    strb.bitIdx    = bitIdx;
    strb.parSample = active && (state == S_PAR) && fullHit;
    strb.finish    = active && (state == S_STOP) && fullHit;
  end
endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import serial_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerOn,
  input  rxStrobe_t  strb,
  input  logic       rxBit,
  input  logic [1:0] parityMode,
  input  logic       readAck,
  output logic [7:0] rxData,
  output logic       rxValid,
  output logic       parityErr,
  output logic       frameErr,
  output logic       overrunErr,
  output logic       errIrq
);
  logic [7:0] shiftReg;
  logic       parAcc;
  logic       parBad, frameBad, overBad;

  always_comb begin
    parBad   = ((parityMode == PAR_ODD)  && !parAcc) ||
               ((parityMode == PAR_EVEN) &&  parAcc);
    frameBad = !rxBit;
    overBad  = rxValid && !readAck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
    end else if (!powerOn || strb.clear) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
    end else if (strb.capture) begin
      shiftReg[strb.bitIdx] <= rxBit;
      parAcc                <= parAcc ^ rxBit;
    end else if (strb.parSample) begin
      parAcc <= parAcc ^ rxBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      rxValid    <= 1'b0;
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
      errIrq     <= 1'b0;
    end else if (!powerOn) begin
      rxData     <= '0;
      rxValid    <= 1'b0;
      parityErr  <= 1'b0;
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
      errIrq     <= 1'b0;
    end else if (strb.finish) begin
      rxData     <= shiftReg;
      rxValid    <= 1'b1;
      parityErr  <= parBad;
      frameErr   <= frameBad;
      overrunErr <= overBad;
      errIrq     <= parBad || frameBad || overBad;
    end else begin
      errIrq <= 1'b0;
      if (readAck) rxValid <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
  import serial_rx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             powerOn,
  input  logic             rxEnable,
  input  logic [1:0]       parityMode,
  input  logic             charLen8,
  input  logic [DIV_W-1:0] divisor,
  input  logic             rxLine,
  input  logic             readAck,
  output logic [7:0]       rxData,
  output logic             rxValid,
  output logic             parityErr,
  output logic             frameErr,
  output logic             overrunErr,
  output logic             errIrq
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] lineSync;
  logic [SYNC_STAGES-1:0] enSync;
  logic                   tick;
  logic                   active;
  logic                   rxBit;
  rxStrobe_t              strb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineSync <= '1;
      enSync   <= '0;
    end else begin
      lineSync <= {lineSync[SYNC_STAGES-2:0], rxLine};
      enSync   <= {enSync[SYNC_STAGES-2:0], rxEnable};
    end
  end

  assign rxBit  = lineSync[SYNC_STAGES-1];
  assign active = powerOn && enSync[SYNC_STAGES-1];

  rx_baud_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rstN(rstN), .run(powerOn), .divisor(divisor), .tick(tick)
  );

  rx_ctrl #(.OVS(OVS)) u_ctrl (
    .clk(clk), .rstN(rstN), .active(active), .tick(tick), .rxBit(rxBit),
    .parityMode(parityMode), .charLen8(charLen8), .strb(strb)
  );

  rx_datapath u_dp (
    .clk(clk), .rstN(rstN), .powerOn(powerOn), .strb(strb), .rxBit(rxBit),
    .parityMode(parityMode), .readAck(readAck), .rxData(rxData),
    .rxValid(rxValid), .parityErr(parityErr), .frameErr(frameErr),
    .overrunErr(overrunErr), .errIrq(errIrq)
  );
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       powerOn,
  input logic [1:0] parityMode,
  input logic       charLen8,
  input logic       readAck,
  input logic [7:0] rxData,
  input logic       rxValid,
  input logic       parityErr,
  input logic       frameErr,
  input logic       overrunErr,
  input logic       errIrq
);
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |-> (parityErr || frameErr || overrunErr)); // R9

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    errIrq |=> !errIrq); // R9

  AST_SEVEN_BIT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxValid) && !charLen8) |-> !rxData[7]); // R2

  AST_ZERO_PAR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (parityMode == 2'b01 && $past(parityMode) == 2'b01) |-> !$rose(parityErr)); // R6

  AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunErr) |-> ($past(rxValid) && !$past(readAck))); // R8

  AST_VALID_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxValid) |-> ($past(readAck) || !$past(powerOn))); // R10

  AST_POWER_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !powerOn |=> (!rxValid && !errIrq && !parityErr)); // R12
endmodule

bind serial_rx_unit serial_rx_checker u_chk (.*);

// File: tb/sim_serial_rx_unit.sv
`timescale 1ns/1ps
module sim_serial_rx_unit;
  localparam int OVS   = 8;
  localparam int DIV_W = 8;
  localparam int BIT   = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             powerOn = 1'b0;
  logic             rxEnable = 1'b0;
  logic [1:0]       parityMode = 2'b00;
  logic             charLen8 = 1'b1;
  logic [DIV_W-1:0] divisor = 8'd2;
  logic             rxLine = 1'b1;
  logic             readAck = 1'b0;
  logic [7:0]       rxData;
  logic             rxValid, parityErr, frameErr, overrunErr, errIrq;

  int testsRun = 0;
  int testsFailed = 0;
  int irqCount = 0;
  int irqBase = 0;

  always #4 clk = ~clk;

  serial_rx_unit #(.OVS(OVS), .DIV_W(DIV_W)) u0 (
    .clk(clk), .rstN(rstN), .powerOn(powerOn), .rxEnable(rxEnable),
    .parityMode(parityMode), .charLen8(charLen8), .divisor(divisor),
    .rxLine(rxLine), .readAck(readAck), .rxData(rxData), .rxValid(rxValid),
    .parityErr(parityErr), .frameErr(frameErr), .overrunErr(overrunErr),
    .errIrq(errIrq)
  );

  always @(posedge clk) if (errIrq) irqCount <= irqCount + 1;

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    rxLine = b;
    idle(BIT);
  endtask

  // start, data LSB first, optional parity, one stop
  task automatic sendFrame(input logic [7:0] d, input int nBits,
                           input bit hasPar, input logic parBit, input logic stopBit);
    sendBit(1'b0);
    for (int i = 0; i < nBits; i++) sendBit(d[i]);
    if (hasPar) sendBit(parBit);
    sendBit(stopBit);
    rxLine = 1'b1;
  endtask

  task automatic ack();
    readAck = 1'b1;
    idle(1);
    readAck = 1'b0;
    idle(1);
  endtask

  task automatic expectChar(input string req, input logic [7:0] d,
                            input logic pe, input logic fe, input logic oe, input int irqs);
    check({req, " data"}, rxData, d);
    check({req, " valid"}, rxValid, 1);
    check({req, " parityErr"}, parityErr, pe);
    check({req, " frameErr"}, frameErr, fe);
    check({req, " overrunErr"}, overrunErr, oe);
    check({req, " irq count"}, irqCount - irqBase, irqs);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    // reset state
    check("R1 reset valid", rxValid, 0);
    check("R1 reset data", rxData, 0);
    check("R9 reset irq", errIrq, 0);
    check("R4 reset parityErr", parityErr, 0);
    powerOn = 1'b1;
    rxEnable = 1'b1;
    idle(20);

    // R1 8-bit no parity, LSB first
    irqBase = irqCount;
    sendFrame(8'hA5, 8, 0, 0, 1);
    expectChar("R1", 8'hA5, 0, 0, 0, 0);
    ack();
    check("R10 valid cleared by ack", rxValid, 0);
    irqBase = irqCount;
    sendFrame(8'h3C, 8, 0, 0, 1);
    expectChar("R1 second pattern", 8'h3C, 0, 0, 0, 0);
    ack();

    // R2 7-bit: only low seven bits sent
    charLen8 = 1'b0;
    irqBase = irqCount;
    sendFrame(8'hD3, 7, 0, 0, 1);
    expectChar("R2 seven bit", 8'h53, 0, 0, 0, 0);
    ack();
    charLen8 = 1'b1;

    // R4 odd parity (R3 encoding 2'b10)
    parityMode = 2'b10;
    irqBase = irqCount;
    sendFrame(8'hA5, 8, 1, 1'b1, 1);
    expectChar("R4 odd good", 8'hA5, 0, 0, 0, 0);
    ack();
    irqBase = irqCount;
    sendFrame(8'hA5, 8, 1, 1'b0, 1);
    expectChar("R4 odd bad", 8'hA5, 1, 0, 0, 1);
    ack();

    // R5 even parity (R3 encoding 2'b11)
    parityMode = 2'b11;
    irqBase = irqCount;
    sendFrame(8'h07, 8, 1, 1'b1, 1);
    expectChar("R5 even good", 8'h07, 0, 0, 0, 0);
    ack();
    irqBase = irqCount;
    sendFrame(8'h07, 8, 1, 1'b0, 1);
    expectChar("R5 even bad", 8'h07, 1, 0, 0, 1);
    ack();

    // R6 zero-parity mode: bit consumed, never judged
    parityMode = 2'b01;
    irqBase = irqCount;
    sendFrame(8'h81, 8, 1, 1'b0, 1);
    expectChar("R6 zero par low", 8'h81, 0, 0, 0, 0);
    ack();
    irqBase = irqCount;
    sendFrame(8'h81, 8, 1, 1'b1, 1);
    expectChar("R6 zero par high", 8'h81, 0, 0, 0, 0);
    ack();
    parityMode = 2'b00;

    // R7 framing error
    irqBase = irqCount;
    sendFrame(8'h5A, 8, 0, 0, 0);
    expectChar("R7 frame", 8'h5A, 0, 1, 0, 1);
    idle(40);
    ack();

    // R8 overrun, back-to-back with a single stop bit
    irqBase = irqCount;
    sendFrame(8'h11, 8, 0, 0, 1);
    sendFrame(8'h22, 8, 0, 0, 1);
    expectChar("R8 overrun", 8'h22, 0, 0, 1, 1);
    ack();
    check("R10 valid cleared after overrun", rxValid, 0);

    // R11 glitch on the line
    irqBase = irqCount;
    rxLine = 1'b0;
    idle(4);
    rxLine = 1'b1;
    idle(60);
    check("R11 glitch no char", rxValid, 0);
    check("R11 glitch no irq", irqCount - irqBase, 0);

    // R12 receive enable low
    rxEnable = 1'b0;
    idle(5);
    sendFrame(8'h66, 8, 0, 0, 1);
    idle(20);
    check("R12 enable off ignored", rxValid, 0);

    // R12 power off
    rxEnable = 1'b1;
    idle(5);
    powerOn = 1'b0;
    sendFrame(8'h77, 8, 0, 0, 1);
    idle(20);
    check("R12 power off ignored", rxValid, 0);
    check("R12 power off data cleared", rxData, 0);
    powerOn = 1'b1;
    idle(20);

    // R13 enable while line already low
    rxEnable = 1'b0;
    idle(6);
    rxLine = 1'b0;
    idle(2);
    irqBase = irqCount;
    rxEnable = 1'b1;
    idle(BIT);
    for (int i = 0; i < 8; i++) sendBit(8'h6E >> i);
    sendBit(1'b1);
    expectChar("R13 enable low start", 8'h6E, 0, 0, 0, 0);
    ack();

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule